// File: doc/BRIEF.md
# DMA Request to Channel Router

This block sits between the peripherals of a chip and a multi-channel DMA engine. Each of the peripheral request lines is a level signal. A table holds one routing entry per line. Each entry names a target channel and carries a valid flag. The router merges the requests that are routed to each channel into one request level for that channel. It also reports when that level starts and stops, so that a separate status block can record these events. The status registers and the transfer engine are outside this block.

Software programs the table through a simple register port. The entries are split across two address windows. Entries 0 to 63 start at byte offset 0x100. The remaining entries start at 0x1100. Both windows use a stride of four bytes. Three words at 0xE0, 0xE4 and 0xE8 are kept as placeholders. They always read zero, and writes to them do nothing. Reads are combinational, and writes take effect at the clock edge. A write that marks an entry valid but names a channel beyond the configured channel count is refused, and the block raises an error pulse.

The request level of each channel is registered. A start of request gives a one-cycle pulse that sets the channel's request-after-stop flag. An end of request gives a one-cycle pulse that sets the channel's end-of-receive flag. Both pulses are produced on the same edge that updates the registered level.

Top module: `dreq_chan_router`

## Requirements
- R1: After reset, every table entry reads 0, which means not valid and channel 0. `chReq`, `rasSet`, `eorSet` and `mapErr` are all 0.
- R2: An entry word holds the channel number in bits 4:0 and the valid flag in bit 7. Bits 6:5 and bits 31:8 are not stored and read as 0. Entry n, for n below 64, sits at byte offset 0x100 + 4·n.
- R3: Entry n, for n from 64 to NUM_REQ−1, sits at byte offset 0x1100 + 4·(n−64).
- R4: A request line whose entry is not valid has no effect on any channel's level or pulses.
- R5: `chReq[c]` equals, one clock after the inputs are sampled, the OR of the request lines whose entries are valid and name channel c. This uses the table contents as they were before that edge.
- R6: On every edge where `chReq[c]` goes from 0 to 1, `rasSet[c]` is 1 for exactly that cycle. At all other times it is 0.
- R7: On every edge where `chReq[c]` goes from 1 to 0, `eorSet[c]` is 1 for exactly that cycle. At all other times it is 0. This also applies when the fall is caused by a table rewrite.
- R8: Offsets 0xE0, 0xE4 and 0xE8 read 0. A write to them changes no table entry and no output.
- R9: A write with bit 7 set and a channel number of NUM_CH or more is not stored. `mapErr` pulses for one cycle after it. A write with bit 7 clear is stored whatever its channel number.
- R10: While several valid entries route requests to one channel, the channel's level stays 1 until the last of those requests drops. No extra `rasSet` or `eorSet` pulse occurs between the first rise and the last fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 16 | Byte offset for register read and write |
| regWrEn | input | 1 | Write strobe for the current address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at `regAddr` |
| reqIn | input | NUM_REQ | Peripheral request levels |
| chReq | output | NUM_CH | Merged request level per channel |
| rasSet | output | NUM_CH | Start-of-request pulse per channel |
| eorSet | output | NUM_CH | End-of-request pulse per channel |
| mapErr | output | 1 | Pulse for a refused write with an out-of-range channel |

## Verification
The bench checks the seam between the two windows: entry 63 is the last one in the low window, and entry 64 is the first one at 0x1100. A decoder that offsets the upper window wrongly would read back or update the wrong line. Shared channels are driven with overlapping requests. A router that reacts to single lines instead of the merged level would pulse `eorSet` while a partner line is still active. The table is rewritten while a request is held. A design that tracks only input edges would miss the fall on the old channel and the rise on the new one. Out-of-range valid writes, invalid writes with large channel numbers and writes to the placeholder words are all followed by readback. This catches a design that stores a refused entry, refuses an entry that should be accepted, or lets the placeholder words alias into the table.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;
  localparam int IDX_W     = 7;
  localparam int CH_W      = 5;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 16;
  localparam int VALID_BIT = 7;

  typedef struct packed {
    logic            valid;
    logic [CH_W-1:0] chan;
  } mapEntry_t;

  typedef struct packed {
    logic             mapWr;
    logic             winHit;
    logic [IDX_W-1:0] idx;
    mapEntry_t        entry;
  } ctrlStrobe_t;
endpackage

// File: rtl/dreq_router_ctrl.sv
module dreq_router_ctrl
  import dreq_router_pkg::*;
#(
  parameter int          NUM_REQ   = 75,
  parameter int          NUM_CH    = 16,
  parameter int          LOW_COUNT = 64,
  parameter logic [31:0] LOW_BASE  = 32'h0000_0100,
  parameter logic [31:0] HIGH_BASE = 32'h0000_1100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrValid,
  input  logic [CH_W-1:0]   wrChan,
  output ctrlStrobe_t       strobe,
  output logic              mapErr
);
  localparam int          HIGH_COUNT = NUM_REQ - LOW_COUNT;
  localparam logic [31:0] LOW_END    = LOW_BASE + 32'(4 * LOW_COUNT);
  localparam logic [31:0] HIGH_END   = HIGH_BASE + 32'(4 * HIGH_COUNT);

  logic [31:0]      addr32;
  logic             aligned;
  logic             hitLow;
  logic             hitHigh;
  logic             badChan;
  logic [IDX_W-1:0] idxLow;
  logic [IDX_W-1:0] idxHigh;

  always_comb begin
    addr32  = 32'(regAddr);
    aligned = (regAddr[1:0] == 2'b00);
    hitLow  = aligned && (addr32 >= LOW_BASE) && (addr32 < LOW_END);
    hitHigh = aligned && (addr32 >= HIGH_BASE) && (addr32 < HIGH_END);
    idxLow  = IDX_W'((addr32 - LOW_BASE) >> 2);
    idxHigh = IDX_W'(LOW_COUNT) + IDX_W'((addr32 - HIGH_BASE) >> 2);
    badChan = wrValid && (32'(wrChan) >= 32'(NUM_CH));

    strobe             = '0;
    strobe.winHit      = hitLow || hitHigh;
    strobe.idx         = hitHigh ? idxHigh : idxLow;
    strobe.entry.valid = wrValid;
    strobe.entry.chan  = wrChan;
    strobe.mapWr       = regWrEn && strobe.winHit && !badChan;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mapErr <= 1'b0;
    else       mapErr <= regWrEn && strobe.winHit && badChan;
  end
endmodule

// File: rtl/dreq_router_dp.sv
module dreq_router_dp
  import dreq_router_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_REQ-1:0] reqIn,
  output mapEntry_t          rdEntry,
  output logic [NUM_CH-1:0]  chReq,
  output logic [NUM_CH-1:0]  rasSet,
  output logic [NUM_CH-1:0]  eorSet
);
  mapEntry_t         mapTable [NUM_REQ];
  logic [NUM_CH-1:0] level;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REQ; r++) mapTable[r] <= '0;
    end else if (strobe.mapWr) begin
      mapTable[strobe.idx] <= strobe.entry;
    end
  end

  assign rdEntry = strobe.winHit ? mapTable[strobe.idx] : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic chanHit;
    always_comb begin
      chanHit = 1'b0;
      for (int r = 0; r < NUM_REQ; r++) begin
        if (mapTable[r].valid && (mapTable[r].chan == CH_W'(c)) && reqIn[r])
          chanHit = 1'b1;
      end
    end
    assign level[c] = chanHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chReq  <= '0;
      rasSet <= '0;
      eorSet <= '0;
    end else begin
      chReq  <= level;
      rasSet <= level & ~chReq;
      eorSet <= ~level & chReq;
    end
  end
endmodule

// File: rtl/dreq_chan_router.sv
module dreq_chan_router
  import dreq_router_pkg::*;
#(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [15:0]        regAddr,
  input  logic               regWrEn,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [NUM_REQ-1:0] reqIn,
  output logic [NUM_CH-1:0]  chReq,
  output logic [NUM_CH-1:0]  rasSet,
  output logic [NUM_CH-1:0]  eorSet,
  output logic               mapErr
);
  ctrlStrobe_t strobe;
  mapEntry_t   rdEntry;
  logic [25:0] unusedWrBits;

  assign unusedWrBits = {regWrData[31:8], regWrData[6:5]};

  dreq_router_ctrl #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .wrValid (regWrData[VALID_BIT]),
    .wrChan  (regWrData[CH_W-1:0]),
    .strobe  (strobe),
    .mapErr  (mapErr)
  );

  dreq_router_dp #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqIn   (reqIn),
    .rdEntry (rdEntry),
    .chReq   (chReq),
    .rasSet  (rasSet),
    .eorSet  (eorSet)
  );

  assign regRdData = 32'({rdEntry.valid, 2'b00, rdEntry.chan});
endmodule

// File: rtl/dreq_router_checker.sv
module dreq_router_checker #(
  parameter int NUM_REQ = 75,
  parameter int NUM_CH  = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [15:0]        regAddr,
  input logic               regWrEn,
  input logic [31:0]        regRdData,
  input logic [NUM_REQ-1:0] reqIn,
  input logic [NUM_CH-1:0]  chReq,
  input logic [NUM_CH-1:0]  rasSet,
  input logic [NUM_CH-1:0]  eorSet,
  input logic               mapErr
);
  assert_ras_on_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    rasSet == (chReq & ~$past(chReq)));

  assert_eor_on_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    eorSet == (~chReq & $past(chReq)));

  assert_no_dual_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rasSet & eorSet) == '0);

  assert_idle_inputs_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqIn == '0) |=> (chReq == '0));

  assert_status_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 16'h00E0 || regAddr == 16'h00E4 || regAddr == 16'h00E8)
      |-> (regRdData == 32'h0));

  assert_err_follows_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    mapErr |-> $past(regWrEn));
endmodule

bind dreq_chan_router dreq_router_checker #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/test_dreq_chan_router.sv
`timescale 1ns/100ps
module test_dreq_chan_router;
  localparam int NREQ = 75;
  localparam int NCH  = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [15:0]     regAddr = '0;
  logic            regWrEn = 1'b0;
  logic [31:0]     regWrData = '0;
  logic [31:0]     regRdData;
  logic [NREQ-1:0] reqIn = '0;
  logic [NCH-1:0]  chReq, rasSet, eorSet;
  logic            mapErr;

  always #2.5 clk = ~clk;

  dreq_chan_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) i_dreq_chan_router (.*);

  int nCmp = 0;
  int nBad = 0;
  bit armed = 0;
  bit done = 0;
  string phase = "R1";

  bit             mValid [NREQ];
  int             mChan  [NREQ];
  logic [NCH-1:0] eReq = '0, eRas = '0, eEor = '0;
  bit             eErr = 0;

  function automatic int decodeIdx(input logic [15:0] a);
    int ai = int'(a);
    if (a[1:0] != 2'b00) return -1;
    if (ai >= 256 && ai < 512) return (ai - 256) / 4;
    if (ai >= 4352 && ai < 4352 + 4 * (NREQ - 64)) return 64 + (ai - 4352) / 4;
    return -1;
  endfunction

  function automatic logic [15:0] entryAddr(input int n);
    if (n < 64) return 16'(256 + 4 * n);
    return 16'(4352 + 4 * (n - 64));
  endfunction

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    logic [NCH-1:0] lvl;
    int idx;
    armed <= 1'b1;
    if (!rstN) begin
      for (int r = 0; r < NREQ; r++) begin mValid[r] = 0; mChan[r] = 0; end
      eReq = '0; eRas = '0; eEor = '0; eErr = 0;
    end else begin
      lvl = '0;
      for (int r = 0; r < NREQ; r++)
        if (mValid[r] && reqIn[r] && mChan[r] < NCH) lvl[mChan[r]] = 1'b1;
      eRas = lvl & ~eReq;
      eEor = ~lvl & eReq;
      eReq = lvl;
      eErr = 0;
      if (regWrEn) begin
        idx = decodeIdx(regAddr);
        if (idx >= 0) begin
          if (regWrData[7] && int'(regWrData[4:0]) >= NCH) eErr = 1;
          else begin mValid[idx] = regWrData[7]; mChan[idx] = int'(regWrData[4:0]); end
        end
      end
    end
  end

  // compare outputs with the model on every clock
  always @(negedge clk) begin
    if (armed) begin
      nCmp++;
      if (chReq !== eReq) begin nBad++;
        $display("FAIL R5 [%s] chReq actual=%h expected=%h", phase, chReq, eReq); end
      nCmp++;
      if (rasSet !== eRas) begin nBad++;
        $display("FAIL R6 [%s] rasSet actual=%h expected=%h", phase, rasSet, eRas); end
      nCmp++;
      if (eorSet !== eEor) begin nBad++;
        $display("FAIL R7 [%s] eorSet actual=%h expected=%h", phase, eorSet, eEor); end
      nCmp++;
      if (mapErr !== eErr) begin nBad++;
        $display("FAIL R9 [%s] mapErr actual=%b expected=%b", phase, mapErr, eErr); end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  task automatic setReq(input int r, input logic v, input int waitCycles);
    @(negedge clk);
    reqIn[r] = v;
    repeat (waitCycles) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    #1;
    check("R1 chReq at reset", 32'(chReq), 32'h0);
    check("R1 mapErr at reset", 32'(mapErr), 32'h0);
    rstN = 1'b1;
    rdChk("R1 entry 0 after reset", entryAddr(0), 32'h0);
    rdChk("R1 entry 74 after reset", entryAddr(74), 32'h0);

    phase = "R2";
    wrReg(entryAddr(3), 32'h0000_0082);
    wrReg(entryAddr(10), 32'hFFFF_FFE7);
    wrReg(entryAddr(63), 32'h0000_0089);
    rdChk("R2 entry 3 readback", 16'h010C, 32'h82);
    rdChk("R2 entry 10 drops bits 6:5 and 31:8", 16'h0128, 32'h87);
    rdChk("R2 entry 63 at top of low window", 16'h01FC, 32'h89);

    phase = "R3";
    wrReg(entryAddr(70), 32'h0000_0085);
    wrReg(entryAddr(64), 32'h0000_008C);
    rdChk("R3 entry 70 at 0x1118", 16'h1118, 32'h85);
    rdChk("R3 entry 64 at 0x1100", 16'h1100, 32'h8C);
    rdChk("R3 entry 63 untouched by entry 64 write", 16'h01FC, 32'h89);

    phase = "R4";
    wrReg(entryAddr(20), 32'h0000_0004);
    setReq(20, 1'b1, 4);
    check("R4 invalid entry does not raise channel 4", 32'(chReq), 32'h0);
    setReq(20, 1'b0, 2);

    phase = "R5/R6/R7";
    setReq(3, 1'b1, 0);
    @(negedge clk);
    check("R6 rasSet pulse on channel 2", 32'(rasSet), 32'h4);
    check("R5 chReq channel 2 high", 32'(chReq), 32'h4);
    repeat (3) @(negedge clk);
    check("R6 rasSet cleared after one cycle", 32'(rasSet), 32'h0);
    setReq(3, 1'b0, 0);
    @(negedge clk);
    check("R7 eorSet pulse on channel 2", 32'(eorSet), 32'h4);

    phase = "R10";
    wrReg(entryAddr(40), 32'h0000_0082);
    setReq(3, 1'b1, 2);
    setReq(40, 1'b1, 2);
    setReq(3, 1'b0, 2);
    check("R10 channel 2 held by remaining request", 32'(chReq), 32'h4);
    check("R10 no eor while a partner request is high", 32'(eorSet), 32'h0);
    setReq(40, 1'b0, 0);
    @(negedge clk);
    check("R10 eor when last request drops", 32'(eorSet), 32'h4);

    phase = "R7 remap";
    setReq(70, 1'b1, 2);
    check("R5 high-window request drives channel 5", 32'(chReq), 32'h20);
    wrReg(entryAddr(70), 32'h0000_0086);
    @(negedge clk);
    check("R7 remap moves request to channel 6", 32'(chReq), 32'h40);
    setReq(70, 1'b0, 2);

    phase = "R9";
    wrReg(entryAddr(3), 32'h0000_009F);
    rdChk("R9 refused write keeps entry 3", entryAddr(3), 32'h82);
    wrReg(entryAddr(72), 32'h0000_001F);
    rdChk("R9 invalid entry with large channel is stored", entryAddr(72), 32'h1F);
    setReq(72, 1'b1, 3);
    setReq(72, 1'b0, 2);

    phase = "R8";
    wrReg(16'h00E0, 32'hFFFF_FFFF);
    wrReg(16'h00E4, 32'hFFFF_FFFF);
    wrReg(16'h00E8, 32'hFFFF_FFFF);
    rdChk("R8 status word 0xE0 reads zero", 16'h00E0, 32'h0);
    rdChk("R8 status word 0xE8 reads zero", 16'h00E8, 32'h0);
    rdChk("R8 entry 0 unchanged", entryAddr(0), 32'h0);
    rdChk("R8 entry 3 unchanged", entryAddr(3), 32'h82);
    check("R8 no channel raised", 32'(chReq), 32'h0);

    phase = "mixed R5/R6/R7/R10";
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf % 6)
        0: reqIn[3]  = ~reqIn[3];
        1: reqIn[40] = ~reqIn[40];
        2: reqIn[70] = ~reqIn[70];
        3: reqIn[20] = ~reqIn[20];
        4: reqIn[10] = ~reqIn[10];
        default: reqIn[64] = ~reqIn[64];
      endcase
    end
    reqIn = '0;
    repeat (3) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule